// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block watches a set of external interrupt lines and decides which one the processor core should service next. Every line carries a programmable priority number, an enable bit, a pending bit and an active bit. A rising edge on a line, or a software write, marks it pending. The controller picks the most urgent pending and enabled line. It raises a take request toward the core only when that line is strictly more urgent than the handler already running.

The core acknowledges with a one-cycle entry strobe and finishes each handler with a one-cycle return strobe. The controller keeps a stack of entered vectors, so each return clears the active bit of the innermost handler. The execution priority then falls back to that of the handler that was preempted, and deferred requests are offered again once nothing more urgent is running. The core's context save and the handler address fetch lie outside this block.

Nesting is tracked by a two-state machine:
- `ST_THREAD`: no handler is running.
- `ST_HANDLER`: at least one handler is active.

It has five named transitions:
- *first entry*: `ST_THREAD` to `ST_HANDLER` on an accepted entry.
- *nest*: `ST_HANDLER` to itself on a further entry, which pushes the stack.
- *unwind*: `ST_HANDLER` to itself on a return while the depth is above one, which pops the stack.
- *final return*: `ST_HANDLER` to `ST_THREAD` on a return at depth one.
- *stray return*: `ST_THREAD` to itself on a return with nothing active, which raises the error flag.

Top module: `irqc_top`

## Requirements
- R1: After reset, all pending, active and enable bits are 0, `take_req` is 0, `exec_valid` is 0, `nest_depth` is 0 and `ret_err` is 0.
- R2: A line that is low at one rising clock edge and high at the next sets its pending bit, and the bit is visible right after that second edge. A line held high does not set the bit again once it has been cleared. A software set also marks a line pending.
- R3: A software clear drops a pending bit. A set from an edge in the same cycle wins over a clear.
- R4: A disabled line can become pending but is never offered. Enabling it while it is still pending makes it eligible.
- R5: Among lines that are pending, enabled and not active, the one with the lowest priority number wins. Ties go to the lowest line index, and `take_vec` carries the winner.
- R6: `take_req` is high only if no handler is active, or if the winner's priority number is strictly below `exec_prio`. Equal or larger numbers stay pending.
- R7: When `core_enter` is seen in a cycle with `take_req` high, `take_vec` becomes active, its pending bit clears and `nest_depth` rises by one. `core_enter` is ignored while `take_req` is low, and also in a cycle that has `core_return` high.
- R8: `core_return` clears the active bit of the most recently entered handler and lowers `nest_depth` by one. `exec_prio` becomes the lowest priority number among the lines still active, and `exec_valid` falls when none remain.
- R9: `core_return` with no active handler sets `ret_err`, which stays set until reset.
- R10: After a return, a request that was held back becomes `take_req` at once if it now beats the restored execution priority.
- R11: A register write is made with `reg_wr` high. `reg_idx` selects the line and `reg_op` selects the action:
  - 0 writes the enable bit from `reg_data[0]`.
  - 1 writes the priority from `reg_data`.
  - 2 sets the pending bit.
  - 3 clears the pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | NUM_IRQ | Interrupt request lines; a rising edge marks the line pending |
| reg_wr | input | 1 | Register write strobe |
| reg_op | input | 2 | Write action: 0 enable, 1 priority, 2 pend set, 3 pend clear |
| reg_idx | input | IDX_W | Line selected by the write |
| reg_data | input | PRIO_W | Write data (priority, or enable in bit 0) |
| core_enter | input | 1 | Core starts the offered handler |
| core_return | input | 1 | Core finishes the innermost handler |
| take_req | output | 1 | Request to take an interrupt |
| take_vec | output | IDX_W | Vector number to take |
| pend_o | output | NUM_IRQ | Pending bits |
| active_o | output | NUM_IRQ | Active bits |
| enable_o | output | NUM_IRQ | Enable bits |
| exec_valid | output | 1 | At least one handler is active |
| exec_prio | output | PRIO_W | Current execution priority (all ones when idle) |
| nest_depth | output | DEPTH_W | Number of nested active handlers |
| ret_err | output | 1 | Sticky flag for a return with nothing active |

## Verification
A stack entry that is wrong, or a lost pop, shows on the very next return. The wrong active bit clears, so `exec_prio` drops to a level that does not match the handlers left running, and `take_req` then either offers a vector that should wait or withholds one that should run. A state machine out of step with the depth counter shows at the first return: either `ret_err` rises with handlers still active, or the depth wraps. An arbitration error shows in the same cycle, as a `take_vec` that breaks the priority order or the tie order.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef enum logic [1:0] {
        OP_ENABLE = 2'd0,
        OP_PRIO   = 2'd1,
        OP_PSET   = 2'd2,
        OP_PCLR   = 2'd3
    } reg_op_e;

    typedef enum logic [0:0] {
        ST_THREAD  = 1'b0,
        ST_HANDLER = 1'b1
    } nest_state_e;

endpackage

// File: rtl/irqc_line_bank.sv
module irqc_line_bank
    import irqc_pkg::*;
#(
    parameter int N  = 8,
    parameter int PW = 3,
    parameter int IW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    irq_in,
    input  logic            reg_wr,
    input  logic [1:0]      reg_op,
    input  logic [IW-1:0]   reg_idx,
    input  logic [PW-1:0]   reg_data,
    input  logic            act_set,
    input  logic [IW-1:0]   act_set_idx,
    input  logic            act_clr,
    input  logic [IW-1:0]   act_clr_idx,
    output logic [N-1:0]    pend,
    output logic [N-1:0]    enable,
    output logic [N-1:0]    active,
    output logic [N*PW-1:0] prio_flat
);

    logic [N-1:0] irq_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_in;
    end

    for (genvar i = 0; i < N; i++) begin : g_line
        logic hit;
        logic edge_set;
        logic sw_set;
        logic sw_clr;
        logic take_clr;

        assign hit      = reg_wr && (reg_idx == IW'(i));
        assign edge_set = irq_in[i] && !irq_q[i];
        assign sw_set   = hit && (reg_op == OP_PSET);
        assign sw_clr   = hit && (reg_op == OP_PCLR);
        assign take_clr = act_set && (act_set_idx == IW'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pend[i]   <= 1'b0;
                enable[i] <= 1'b0;
                active[i] <= 1'b0;
                prio_flat[i*PW +: PW] <= '0;
            end else begin
                if (edge_set || sw_set)       pend[i] <= 1'b1;
                else if (sw_clr || take_clr)  pend[i] <= 1'b0;

                if (hit && reg_op == OP_ENABLE) enable[i] <= reg_data[0];
                if (hit && reg_op == OP_PRIO)   prio_flat[i*PW +: PW] <= reg_data;

                if (take_clr)                                   active[i] <= 1'b1;
                else if (act_clr && act_clr_idx == IW'(i))      active[i] <= 1'b0;
            end
        end

        // R2
        edge_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_in[i] && !$past(irq_in[i])) |=> pend[i]);
    end

endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
    parameter int N  = 8,
    parameter int PW = 3,
    parameter int IW = 3
) (
    input  logic [N-1:0]    cand,
    input  logic [N*PW-1:0] prio_flat,
    output logic            found,
    output logic [IW-1:0]   win_idx,
    output logic [PW-1:0]   win_prio
);

    always_comb begin
        found    = 1'b0;
        win_idx  = '0;
        win_prio = '1;
        for (int i = 0; i < N; i++) begin
            if (cand[i] && (!found || prio_flat[i*PW +: PW] < win_prio)) begin
                found    = 1'b1;
                win_idx  = IW'(i);
                win_prio = prio_flat[i*PW +: PW];
            end
        end
    end

endmodule

// File: rtl/irqc_nest_stack.sv
module irqc_nest_stack
    import irqc_pkg::*;
#(
    parameter int N  = 8,
    parameter int IW = 3,
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_req,
    input  logic          pop_req,
    input  logic [IW-1:0] push_idx,
    output logic [DW-1:0] depth,
    output logic          act_set,
    output logic [IW-1:0] act_set_idx,
    output logic          act_clr,
    output logic [IW-1:0] act_clr_idx,
    output logic          ret_err
);

    nest_state_e   state_q, state_d;
    logic [IW-1:0] stk [N];
    logic [IW-1:0] wr_ptr;
    logic [IW-1:0] top_ptr;
    logic          stray;

    assign wr_ptr  = IW'(depth);
    assign top_ptr = IW'(depth - DW'(1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_THREAD:  if (push_req && !pop_req) state_d = ST_HANDLER;
            ST_HANDLER: if (pop_req && depth == DW'(1)) state_d = ST_THREAD;
        endcase
    end

    always_comb begin
        act_set     = push_req && !pop_req && (depth < DW'(N));
        act_set_idx = push_idx;
        act_clr     = pop_req && (state_q == ST_HANDLER);
        act_clr_idx = stk[top_ptr];
        stray       = pop_req && (state_q == ST_THREAD);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_THREAD;
            depth   <= '0;
            ret_err <= 1'b0;
        end else begin
            state_q <= state_d;
            if (act_clr)      depth <= depth - DW'(1);
            else if (act_set) depth <= depth + DW'(1);
            if (stray)        ret_err <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (act_set) stk[wr_ptr] <= push_idx;
    end

    // R9
    stray_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && depth == '0) |=> ret_err);

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret_err |=> ret_err);

    // R7
    depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        depth <= DW'(N));

    // R8
    state_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_THREAD) == (depth == '0));

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int NUM_IRQ = 8,
    parameter int PRIO_W  = 3,
    parameter int IDX_W   = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1,
    parameter int DEPTH_W = $clog2(NUM_IRQ + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_in,
    input  logic               reg_wr,
    input  logic [1:0]         reg_op,
    input  logic [IDX_W-1:0]   reg_idx,
    input  logic [PRIO_W-1:0]  reg_data,
    input  logic               core_enter,
    input  logic               core_return,
    output logic               take_req,
    output logic [IDX_W-1:0]   take_vec,
    output logic [NUM_IRQ-1:0] pend_o,
    output logic [NUM_IRQ-1:0] active_o,
    output logic [NUM_IRQ-1:0] enable_o,
    output logic               exec_valid,
    output logic [PRIO_W-1:0]  exec_prio,
    output logic [DEPTH_W-1:0] nest_depth,
    output logic               ret_err
);

    logic [NUM_IRQ*PRIO_W-1:0] prio_flat;
    logic [NUM_IRQ-1:0]        cand;
    logic                      pick_any;
    logic [IDX_W-1:0]          pick_idx;
    logic [PRIO_W-1:0]         pick_prio;
    logic                      exec_idx_unused_ok;
    logic [IDX_W-1:0]          exec_idx;
    logic                      act_set, act_clr;
    logic [IDX_W-1:0]          act_set_idx, act_clr_idx;
    logic                      enter_ok;

    irqc_line_bank #(.N(NUM_IRQ), .PW(PRIO_W), .IW(IDX_W)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_in      (irq_in),
        .reg_wr      (reg_wr),
        .reg_op      (reg_op),
        .reg_idx     (reg_idx),
        .reg_data    (reg_data),
        .act_set     (act_set),
        .act_set_idx (act_set_idx),
        .act_clr     (act_clr),
        .act_clr_idx (act_clr_idx),
        .pend        (pend_o),
        .enable      (enable_o),
        .active      (active_o),
        .prio_flat   (prio_flat)
    );

    assign cand = pend_o & enable_o & ~active_o;

    irqc_arbiter #(.N(NUM_IRQ), .PW(PRIO_W), .IW(IDX_W)) u_pick (
        .cand      (cand),
        .prio_flat (prio_flat),
        .found     (pick_any),
        .win_idx   (pick_idx),
        .win_prio  (pick_prio)
    );

    irqc_arbiter #(.N(NUM_IRQ), .PW(PRIO_W), .IW(IDX_W)) u_exec (
        .cand      (active_o),
        .prio_flat (prio_flat),
        .found     (exec_idx_unused_ok),
        .win_idx   (exec_idx),
        .win_prio  (exec_prio)
    );

    assign exec_valid = exec_idx_unused_ok;
    assign take_req   = pick_any && (!exec_valid || pick_prio < exec_prio);
    assign take_vec   = pick_idx;
    assign enter_ok   = core_enter && take_req;

    irqc_nest_stack #(.N(NUM_IRQ), .IW(IDX_W), .DW(DEPTH_W)) u_stack (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_req    (enter_ok),
        .pop_req     (core_return),
        .push_idx    (pick_idx),
        .depth       (nest_depth),
        .act_set     (act_set),
        .act_set_idx (act_set_idx),
        .act_clr     (act_clr),
        .act_clr_idx (act_clr_idx),
        .ret_err     (ret_err)
    );

    // R5
    offer_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_req |-> (pend_o[take_vec] && enable_o[take_vec] && !active_o[take_vec]));

    // R7
    depth_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(active_o) == int'(nest_depth));

    // R6
    entry_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_enter && take_req && !core_return && !reg_wr) |=>
            (exec_valid && exec_prio == $past(pick_prio) && active_o[$past(take_vec)]));

    // R8
    return_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_return && nest_depth != '0) |=> nest_depth == $past(nest_depth) - DEPTH_W'(1));

    // R8
    exec_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nest_depth == '0) |-> !exec_valid);

    wire unused_exec_idx = ^exec_idx;

endmodule

// File: tb/irqc_top_tb.sv
`timescale 1ns/1ps
module irqc_top_tb;

    localparam int N  = 8;
    localparam int PW = 3;
    localparam int IW = 3;
    localparam int DW = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [N-1:0]  irq_in;
    logic          reg_wr;
    logic [1:0]    reg_op;
    logic [IW-1:0] reg_idx;
    logic [PW-1:0] reg_data;
    logic          core_enter, core_return;
    logic          take_req;
    logic [IW-1:0] take_vec;
    logic [N-1:0]  pend_o, active_o, enable_o;
    logic          exec_valid;
    logic [PW-1:0] exec_prio;
    logic [DW-1:0] nest_depth;
    logic          ret_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    irqc_top #(.NUM_IRQ(N), .PRIO_W(PW)) u_dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .reg_wr(reg_wr), .reg_op(reg_op), .reg_idx(reg_idx), .reg_data(reg_data),
        .core_enter(core_enter), .core_return(core_return),
        .take_req(take_req), .take_vec(take_vec),
        .pend_o(pend_o), .active_o(active_o), .enable_o(enable_o),
        .exec_valid(exec_valid), .exec_prio(exec_prio),
        .nest_depth(nest_depth), .ret_err(ret_err)
    );

    // priorities per line: 4,2,2,6,7,1,3,1 ; line 4 left disabled
    localparam int PRIO_CFG [N] = '{4, 2, 2, 6, 7, 1, 3, 1};

    // {set mask[11:4], expected take_req[3], expected take_vec[2:0]}
    localparam logic [11:0] VEC_TBL [9] = '{
        12'h000, 12'h018, 12'h069, 12'hA0D, 12'h88F,
        12'h100, 12'h198, 12'hFFD, 12'h48E
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic reg_write(logic [1:0] op, int idx, int data);
        reg_wr   = 1'b1;
        reg_op   = op;
        reg_idx  = IW'(idx);
        reg_data = PW'(data);
        tick();
        reg_wr   = 1'b0;
    endtask

    task automatic pulse_enter();
        core_enter = 1'b1;
        tick();
        core_enter = 1'b0;
    endtask

    task automatic pulse_return();
        core_return = 1'b1;
        tick();
        core_return = 1'b0;
    endtask

    task automatic clear_all();
        for (int i = 0; i < N; i++) reg_write(2'd3, i, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; irq_in = '0; reg_wr = 1'b0; reg_op = '0; reg_idx = '0;
        reg_data = '0; core_enter = 1'b0; core_return = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tick();

        // R1 reset state
        check("R1 pend", int'(pend_o), 0);
        check("R1 active", int'(active_o), 0);
        check("R1 enable", int'(enable_o), 0);
        check("R1 take_req", int'(take_req), 0);
        check("R1 exec_valid", int'(exec_valid), 0);
        check("R1 depth", int'(nest_depth), 0);
        check("R1 ret_err", int'(ret_err), 0);

        // R11 configuration through the register port
        for (int i = 0; i < N; i++) begin
            reg_write(2'd1, i, PRIO_CFG[i]);
            reg_write(2'd0, i, (i == 4) ? 0 : 1);
        end
        check("R11 enable", int'(enable_o), 8'hEF);

        // R5 arbitration table (R4 row with only the disabled line)
        for (int r = 0; r < 9; r++) begin
            clear_all();
            for (int b = 0; b < N; b++)
                if (VEC_TBL[r][4+b]) reg_write(2'd2, b, 0);
            check("R5 R4 table req", int'(take_req), int'(VEC_TBL[r][3]));
            if (VEC_TBL[r][3]) check("R5 table vec", int'(take_vec), int'(VEC_TBL[r][2:0]));
            check("R6 table idle", int'(exec_valid), 0);
        end
        clear_all();

        // R2 edge sets pending
        irq_in[2] = 1'b1;
        tick();
        check("R2 edge pend", int'(pend_o[2]), 1);
        check("R5 edge take", int'(take_req), 1);
        check("R5 edge vec", int'(take_vec), 2);

        // R7 entry
        pulse_enter();
        check("R7 active", int'(active_o[2]), 1);
        check("R7 pend cleared", int'(pend_o[2]), 0);
        check("R7 depth", int'(nest_depth), 1);
        check("R8 exec prio", int'(exec_prio), 2);
        tick();
        check("R2 level no reset", int'(pend_o[2]), 0);

        // R6 lower and equal priority held back
        irq_in[6] = 1'b1;
        tick();
        check("R2 nested edge", int'(pend_o[6]), 1);
        check("R6 lower held", int'(take_req), 0);
        reg_write(2'd2, 1, 0);
        check("R6 equal held", int'(take_req), 0);
        reg_write(2'd2, 5, 0);
        check("R6 preempt req", int'(take_req), 1);
        check("R6 preempt vec", int'(take_vec), 5);
        pulse_enter();
        check("R7 nest depth", int'(nest_depth), 2);
        check("R8 nest prio", int'(exec_prio), 1);

        // R7 entry without request ignored
        pulse_enter();
        check("R7 ignored depth", int'(nest_depth), 2);
        check("R7 ignored active", int'(active_o), 8'h24);

        // R8 unwind
        pulse_return();
        check("R8 pop active", int'(active_o), 8'h04);
        check("R8 pop depth", int'(nest_depth), 1);
        check("R8 restored prio", int'(exec_prio), 2);
        check("R6 still held", int'(take_req), 0);
        pulse_return();
        check("R8 idle", int'(exec_valid), 0);
        check("R10 deferred req", int'(take_req), 1);
        check("R10 deferred vec", int'(take_vec), 1);
        pulse_enter();
        check("R6 lower behind 1", int'(take_req), 0);
        pulse_return();
        check("R10 next vec", int'(take_vec), 6);
        check("R10 next req", int'(take_req), 1);
        pulse_enter();
        pulse_return();
        irq_in = '0;
        tick();
        check("R8 all done", int'(active_o), 0);

        // R4 disabled line
        reg_write(2'd0, 3, 0);
        reg_write(2'd2, 3, 0);
        check("R4 pend while off", int'(pend_o[3]), 1);
        check("R4 not offered", int'(take_req), 0);
        reg_write(2'd0, 3, 1);
        check("R4 offered", int'(take_req), 1);
        check("R4 vec", int'(take_vec), 3);

        // R3 clear, and set beats clear
        reg_write(2'd3, 3, 0);
        check("R3 clear", int'(pend_o[3]), 0);
        irq_in[0] = 1'b1;
        reg_write(2'd3, 0, 0);
        check("R3 set wins", int'(pend_o[0]), 1);

        // R9 stray return, then enter+return together
        reg_write(2'd3, 0, 0);
        irq_in = '0;
        pulse_return();
        check("R9 err", int'(ret_err), 1);
        reg_write(2'd2, 0, 0);
        core_enter = 1'b1;
        core_return = 1'b1;
        tick();
        core_enter = 1'b0;
        core_return = 1'b0;
        check("R7 enter with return", int'(active_o), 0);
        check("R7 depth unchanged", int'(nest_depth), 0);
        check("R9 sticky", int'(ret_err), 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule